// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block buffers words between two unrelated clock domains. A producer pushes words on the write clock, and a consumer pops them on the read clock. The storage is a two-port array. Its write port is clocked by the producer and its read port by the consumer.

Each side keeps its own binary pointer. The pointer is one bit wider than the array address, and it also has a Gray-coded copy. Only the Gray copy crosses to the opposite domain, through a two-flop synchronizer. The full flag belongs to the write domain and the empty flag to the read domain. Each flag rises on the same edge as the access that causes it. Each may fall a few destination cycles after the opposite side has made room or delivered data.

An almost-full flag gives a writer time to back off. This matters when the writer sees the flag through its own two-flop synchronizer. A write attempted while full is dropped and latches an overflow bit until the writer clears it. A read attempted while empty is dropped and latches an underflow bit until the read domain is reset.

Top module: `cdc_fifo`

## Requirements
- R1: After both resets are released, empty_o=1, full_o=0, afull_o=0, ovf_o=0, udf_o=0 and rd_data_o=0.
- R2: Words come out in the order they were accepted. A read is accepted on a read-clock edge where rd_en_i=1 and empty_o=0. The popped word appears on rd_data_o right after that edge and holds until the next accepted read.
- R3: With the read side idle, full_o rises right after the write-clock edge that stores the word filling all DEPTH=2^AW locations. A write is accepted when wr_en_i=1 and full_o=0. full_o stays low after each earlier write.
- R4: With the write side idle, empty_o rises right after the read-clock edge that removes the last stored word. empty_o stays low after each earlier read.
- R5: A write attempted while full_o=1 does not store its word and does not disturb the stored words. On the following write edge it sets ovf_o.
- R6: ovf_o stays set until a write edge samples ovf_clr_i=1, and then it falls. A new overflow on that same edge takes precedence.
- R7: A read attempted while empty_o=1 leaves rd_data_o and the stored contents unchanged. It sets udf_o, which then stays set until the read reset.
- R8: afull_o is registered on the write clock. After each write edge it equals (write pointer minus synchronized read pointer) >= AF_LEVEL, where AF_LEVEL defaults to DEPTH-4.
- R9: After a read frees a location in a full FIFO, full_o falls within 8 write-clock cycles.
- R10: After a write into an empty FIFO, empty_o falls within 8 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| wrst_ni | input | 1 | Asynchronous active-low reset, write domain |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Word to store |
| ovf_clr_i | input | 1 | Clears the sticky overflow bit |
| full_o | output | 1 | No free location (write domain) |
| afull_o | output | 1 | Occupancy at or above AF_LEVEL (write domain) |
| ovf_o | output | 1 | Sticky: a write was attempted while full |
| rclk_i | input | 1 | Read clock |
| rrst_ni | input | 1 | Asynchronous active-low reset, read domain |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DW | Last popped word (registered) |
| empty_o | output | 1 | No stored word (read domain) |
| udf_o | output | 1 | Sticky: a read was attempted while empty |

## Verification
A pointer that advances on a refused access, or a Gray copy that is decoded wrongly, shows up on rd_data_o. The corrupted word or the missing word appears on the first read that reaches that location, at most DEPTH reads later. A flag compare built from the wrong pointer bits shows up on the very edge where full_o or empty_o should rise, or as a flag that fails to fall within a few cycles of the other side's access. A broken sticky bit shows on ovf_o or udf_o one edge after the refused access or the clear.

// File: rtl/cdc_fifo_pkg.sv
`timescale 1ns/1ps
package cdc_fifo_pkg;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cdc_fifo_sync.sv
`timescale 1ns/1ps
module cdc_fifo_sync
  import cdc_fifo_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(SYNC_STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/cdc_fifo_mem.sv
`timescale 1ns/1ps
module cdc_fifo_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni)  rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cdc_fifo_wside.sv
`timescale 1ns/1ps
module cdc_fifo_wside #(
  parameter int AW       = 4,
  parameter int AF_LEVEL = 12
) (
  input  logic        wclk_i,
  input  logic        wrst_ni,
  input  logic        wr_en_i,
  input  logic        ovf_clr_i,
  input  logic [AW:0] rgray_i,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        fire_o,
  output logic        full_o,
  output logic        afull_o,
  output logic        ovf_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_q, wbin_nxt, wgray_q, wgray_nxt;
  logic [PW-1:0] rbin_view, fill_nxt, full_ptrn;
  logic          fire, full_q, afull_q, ovf_q;

  assign fire      = wr_en_i & ~full_q;
  assign wbin_nxt  = wbin_q + {{AW{1'b0}}, fire};
  assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
  // full: the two upper Gray bits differ from the read pointer, the rest match
  assign full_ptrn = {~rgray_i[PW-1:PW-2], rgray_i[PW-3:0]};

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_view[i] = ^(rgray_i >> i);
  end

  assign fill_nxt = wbin_nxt - rbin_view;

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
      full_q  <= (wgray_nxt == full_ptrn);
      afull_q <= (fill_nxt >= PW'(AF_LEVEL));
      ovf_q   <= (wr_en_i & full_q) | (ovf_q & ~ovf_clr_i);
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign fire_o  = fire;
  assign full_o  = full_q;
  assign afull_o = afull_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/cdc_fifo_rside.sv
`timescale 1ns/1ps
module cdc_fifo_rside #(
  parameter int AW = 4
) (
  input  logic        rclk_i,
  input  logic        rrst_ni,
  input  logic        rd_en_i,
  input  logic [AW:0] wgray_i,
  output logic [AW:0] rbin_o,
  output logic [AW:0] rgray_o,
  output logic        fire_o,
  output logic        empty_o,
  output logic        udf_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_nxt, rgray_q, rgray_nxt;
  logic          fire, empty_q, udf_q;

  assign fire      = rd_en_i & ~empty_q;
  assign rbin_nxt  = rbin_q + {{AW{1'b0}}, fire};
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      udf_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rgray_nxt;
      empty_q <= (rgray_nxt == wgray_i);
      udf_q   <= udf_q | (rd_en_i & empty_q);
    end
  end

  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
  assign fire_o  = fire;
  assign empty_o = empty_q;
  assign udf_o   = udf_q;
endmodule

// File: rtl/cdc_fifo.sv
`timescale 1ns/1ps
module cdc_fifo #(
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int AF_LEVEL = (1 << AW) - 4
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ovf_clr_i,
  output logic          full_o,
  output logic          afull_o,
  output logic          ovf_o,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          udf_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_rsync, rgray_wsync;
  logic          wr_fire, rd_fire;

  cdc_fifo_wside #(.AW(AW), .AF_LEVEL(AF_LEVEL)) u_wside (
    .wclk_i   (wclk_i),
    .wrst_ni  (wrst_ni),
    .wr_en_i  (wr_en_i),
    .ovf_clr_i(ovf_clr_i),
    .rgray_i  (rgray_wsync),
    .wbin_o   (wptr_bin),
    .wgray_o  (wptr_gray),
    .fire_o   (wr_fire),
    .full_o   (full_o),
    .afull_o  (afull_o),
    .ovf_o    (ovf_o)
  );

  cdc_fifo_rside #(.AW(AW)) u_rside (
    .rclk_i (rclk_i),
    .rrst_ni(rrst_ni),
    .rd_en_i(rd_en_i),
    .wgray_i(wgray_rsync),
    .rbin_o (rptr_bin),
    .rgray_o(rptr_gray),
    .fire_o (rd_fire),
    .empty_o(empty_o),
    .udf_o  (udf_o)
  );

  cdc_fifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wptr_gray),
    .q_o   (wgray_rsync)
  );

  cdc_fifo_sync #(.W(PW)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .d_i   (rptr_gray),
    .q_o   (rgray_wsync)
  );

  cdc_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_fire),
    .waddr_i(wptr_bin[AW-1:0]),
    .wdata_i(wr_data_i),
    .rclk_i (rclk_i),
    .rrst_ni(rrst_ni),
    .re_i   (rd_fire),
    .raddr_i(rptr_bin[AW-1:0]),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/cdc_fifo_chk.sv
`timescale 1ns/1ps
module cdc_fifo_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          wclk_i,
  input logic          wrst_ni,
  input logic          wr_en_i,
  input logic          ovf_clr_i,
  input logic          full_o,
  input logic          afull_o,
  input logic          ovf_o,
  input logic          rclk_i,
  input logic          rrst_ni,
  input logic          rd_en_i,
  input logic [DW-1:0] rd_data_o,
  input logic          empty_o,
  input logic          udf_o,
  input logic [AW:0]   wptr_bin,
  input logic [AW:0]   rptr_bin
);
  assert_no_overflow_R5: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_en_i && full_o) |=> $stable(wptr_bin));

  assert_ovf_set_R5: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_en_i && full_o) |=> ovf_o);

  assert_ovf_sticky_R6: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  assert_ovf_clear_R6: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (ovf_clr_i && !(wr_en_i && full_o)) |=> !ovf_o);

  assert_full_implies_afull_R8: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_o |-> afull_o);

  assert_no_underflow_R7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_en_i && empty_o) |=> ($stable(rptr_bin) && $stable(rd_data_o)));

  assert_udf_set_R7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_en_i && empty_o) |=> udf_o);

  assert_udf_sticky_R7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    udf_o |=> udf_o);
endmodule

bind cdc_fifo cdc_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i   (wclk_i),
  .wrst_ni  (wrst_ni),
  .wr_en_i  (wr_en_i),
  .ovf_clr_i(ovf_clr_i),
  .full_o   (full_o),
  .afull_o  (afull_o),
  .ovf_o    (ovf_o),
  .rclk_i   (rclk_i),
  .rrst_ni  (rrst_ni),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .empty_o  (empty_o),
  .udf_o    (udf_o),
  .wptr_bin (wptr_bin),
  .rptr_bin (rptr_bin)
);

// File: tb/cdc_fifo_bench.sv
`timescale 1ns/1ps
module cdc_fifo_bench;
  localparam int DW       = 16;
  localparam int AW       = 4;
  localparam int DEPTH    = 1 << AW;
  localparam int AF_LEVEL = DEPTH - 4;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst_n = 1'b0, rrst_n = 1'b0;
  logic          wr_en_i = 1'b0, ovf_clr_i = 1'b0, rd_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          full_o, afull_o, ovf_o, empty_o, udf_o;
  logic [DW-1:0] rd_data_o;

  int unsigned n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [DW-1:0] model [$];

  always #4.0 wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  cdc_fifo #(.DW(DW), .AW(AW), .AF_LEVEL(AF_LEVEL)) u_cdc_fifo (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ovf_clr_i(ovf_clr_i), .full_o(full_o), .afull_o(afull_o), .ovf_o(ovf_o),
    .rclk_i(rclk), .rrst_ni(rrst_n), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .empty_o(empty_o), .udf_o(udf_o)
  );

  function automatic bit exp_afull(int occ);
    return occ >= AF_LEVEL;
  endfunction

  function automatic bit exp_full(int occ);
    return occ == DEPTH;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr_one(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    acc = !full_o;
    @(posedge wclk);
    if (acc) model.push_back(d);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd_one(input bit en, output bit acc);
    logic [DW-1:0] exp;
    @(negedge rclk);
    rd_en_i = en;
    acc = en && !empty_o;
    @(posedge rclk);
    #1 rd_en_i = 1'b0;
    @(negedge rclk);
    if (acc) begin
      if (model.size() == 0) begin
        chk("R2", "read accepted with nothing stored", 32'(1), 32'(0));
      end else begin
        exp = model.pop_front();
        chk("R2", "read data order", 32'(rd_data_o), 32'(exp));
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit acc;
    bit seen;
    logic [DW-1:0] last;
    void'($urandom(32'h5eed_1234));

    #30;
    @(negedge wclk) wrst_n = 1'b1;
    @(negedge rclk) rrst_n = 1'b1;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);

    // R1 reset state
    chk("R1", "empty_o", 32'(empty_o), 32'(1));
    chk("R1", "full_o", 32'(full_o), 32'(0));
    chk("R1", "afull_o", 32'(afull_o), 32'(0));
    chk("R1", "ovf_o", 32'(ovf_o), 32'(0));
    chk("R1", "udf_o", 32'(udf_o), 32'(0));
    chk("R1", "rd_data_o", 32'(rd_data_o), 32'(0));

    // R3 / R8 fill with reader idle
    for (int k = 1; k <= DEPTH; k++) begin
      wr_one(DW'(16'h0100 + k), acc);
      @(negedge wclk);
      chk("R3", $sformatf("full after %0d writes", k), 32'(full_o), 32'(exp_full(k)));
      chk("R8", $sformatf("afull after %0d writes", k), 32'(afull_o), 32'(exp_afull(k)));
    end

    // R5 write while full
    wr_one(16'hDEAD, acc);
    chk("R5", "write accepted while full", 32'(acc), 32'(0));
    @(negedge wclk);
    chk("R5", "ovf_o after refused write", 32'(ovf_o), 32'(1));
    chk("R5", "full_o after refused write", 32'(full_o), 32'(1));

    // R6 sticky then clear
    repeat (4) @(negedge wclk);
    chk("R6", "ovf_o held", 32'(ovf_o), 32'(1));
    ovf_clr_i = 1'b1;
    @(posedge wclk);
    #1 ovf_clr_i = 1'b0;
    @(negedge wclk);
    chk("R6", "ovf_o after clear", 32'(ovf_o), 32'(0));

    // R9 full falls after one read
    rd_one(1'b1, acc);
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge wclk);
      if (!full_o) seen = 1'b1;
    end
    chk("R9", "full_o cleared within 8 write cycles", 32'(seen), 32'(1));
    wr_one(16'h0200, acc);
    @(negedge wclk);
    chk("R3", "full after refill", 32'(full_o), 32'(1));

    // R4 drain with writer idle, R2 data checked in rd_one
    repeat (6) @(negedge rclk);
    for (int k = 1; k <= DEPTH; k++) begin
      rd_one(1'b1, acc);
      chk("R4", $sformatf("empty after %0d reads", k), 32'(empty_o), 32'(k == DEPTH));
    end

    // R7 read while empty
    last = rd_data_o;
    rd_one(1'b1, acc);
    chk("R7", "read accepted while empty", 32'(acc), 32'(0));
    chk("R7", "rd_data_o unchanged", 32'(rd_data_o), 32'(last));
    chk("R7", "udf_o set", 32'(udf_o), 32'(1));
    chk("R7", "empty_o held", 32'(empty_o), 32'(1));
    repeat (3) @(negedge rclk);
    chk("R7", "udf_o sticky", 32'(udf_o), 32'(1));

    // R10 empty falls after one write
    wr_one(16'h0300, acc);
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge rclk);
      if (!empty_o) seen = 1'b1;
    end
    chk("R10", "empty_o cleared within 8 read cycles", 32'(seen), 32'(1));
    rd_one(1'b1, acc);

    // random traffic, R2 ordering across both domains
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          bit a;
          if (($urandom % 4) != 0) wr_one(DW'($urandom), a);
          else @(negedge wclk);
        end
      end
      begin
        for (int i = 0; i < 2400; i++) begin
          bit a;
          rd_one(($urandom % 3) != 0, a);
        end
      end
    join

    for (int i = 0; i < 4 * DEPTH && model.size() != 0; i++) rd_one(1'b1, acc);
    repeat (6) @(negedge rclk);
    chk("R2", "words left in model", 32'(model.size()), 32'(0));
    chk("R4", "empty after final drain", 32'(empty_o), 32'(1));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule